// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This unit sits between a set of peripheral devices and a processor core and decides when the core should take an interrupt. Each device drives a 3-bit level code. A nonzero code is a request on that level, and code zero means the device is disconnected. A separate input raises requests on level 0, the most urgent level. Requests from all devices are merged per level. A global switch and per-level enables for levels 1 to 7 then filter them, and a hold register blocks any level that is already in service, together with everything below it. When a request gets through, the unit raises a one-cycle accept strobe. The strobe carries the accepted level and that level's dispatch vector address, and the level becomes held.

Software controls the unit through a single write word. The word has separate bit fields that set and clear level enables, a pair of bits that switch the whole system on and off, and a bit that wipes all state. A read port shows the current enables. The core signals the end of a service routine with a dismiss pulse. Each pulse releases only the most urgent held level, so a routine that preempted a lower one unwinds in order.

Top module: `pri_int_ctrl`

## Requirements
- R1: After the asynchronous reset, `ack` is low, `rd_mask` reads 0 (system off, all levels 1..7 disabled) and no level is held.
- R2: Device `d` drives its level on `dev_code[3d+2:3d]`. Codes 1..7 request that level, and requests from several devices on one level merge by OR. Code 0 never raises a request.
- R3: A level 0 request (`lvl0_req`) needs no per-level enable. It is accepted whenever the system is on and level 0 is not held, and it preempts held levels 1..7.
- R4: Level n (1..7) is accepted only if its enable bit is set. In a write, `wr_data[n-1]` sets the enable of level n and `wr_data[n+6]` clears it. Clear wins if both are given. `rd_mask[n]` shows the enable of level n.
- R5: Nothing is accepted while the system is off. `wr_data[14]` switches the system on and `wr_data[15]` switches it off, with off winning if both are set. `rd_mask[0]` shows the on state.
- R6: When several eligible levels request in one cycle, the lowest-numbered level is accepted. At most one level is accepted per cycle.
- R7: An accepted level becomes held. While any level m is held, requests on levels m..7 are not accepted, but levels below m are.
- R8: A `dismiss` pulse releases only the lowest-numbered held level. Dismiss with nothing held has no effect.
- R9: A request seen at a clock edge is reported after that edge: `ack` is high for one cycle, `ack_lvl` gives the level and `ack_vec` gives 32 + 2*level (octal 040 + 2n).
- R10: A write with `wr_data[16]` set releases all holds, disables all levels, switches the system off and suppresses any acceptance in that cycle.
- R11: Within a cycle, acceptance uses the enables and holds as they stood before that cycle's write and dismiss take effect. A dismiss and an acceptance in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_code | input | 3*NUM_DEV | Level code per device, 0 = disconnected |
| lvl0_req | input | 1 | Request on the unmaskable level 0 |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 17 | Control word: enable set [6:0], enable clear [13:7], on [14], off [15], wipe [16] |
| dismiss | input | 1 | Release the most urgent held level |
| rd_mask | output | 8 | Level enables [7:1] and system on [0] |
| ack | output | 1 | One-cycle accept strobe |
| ack_lvl | output | 3 | Accepted level |
| ack_vec | output | VEC_W | Dispatch vector address of the accepted level |

## Verification
The delicate coincidences are an acceptance landing in the same cycle as a dismiss, and an acceptance landing in the same cycle as a control write, including a wipe. The bench provokes both on purpose. It raises a more urgent request in the very cycle the core dismisses a lower held level. It also writes enable-clear, system-off and wipe words while a request is pending. A behavioural model that applies the pre-cycle state to arbitration and then retires holds and writes is compared with the outputs every cycle, so any wrong ordering shows up as a mismatched strobe or a missing later acceptance.

// File: rtl/pri_int_pkg.sv
package pri_int_pkg;
  localparam int LVL_N = 8;
  localparam int LVL_W = $clog2(LVL_N);

  typedef logic [LVL_N-1:0] lvl_vec_t;
  typedef logic [LVL_W-1:0] lvl_num_t;

  // control word; field positions are software-visible
  typedef struct packed {
    logic             wipe;
    logic             sys_off;
    logic             sys_on;
    logic [LVL_N-2:0] en_clr;   // bit k -> level k+1
    logic [LVL_N-2:0] en_set;   // bit k -> level k+1
  } pi_wr_t;

  localparam int WR_W = $bits(pi_wr_t);
endpackage

// File: rtl/pi_req_gather.sv
module pi_req_gather
  import pri_int_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic [NUM_DEV*LVL_W-1:0] dev_code,
  input  logic                     lvl0_req,
  output lvl_vec_t                 lvl_req
);
  function automatic logic any_on(input logic [NUM_DEV*LVL_W-1:0] codes,
                                  input int unsigned lv);
    logic hit;
    hit = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (codes[d*LVL_W +: LVL_W] == lvl_num_t'(lv)) hit = 1'b1;
    end
    return hit;
  endfunction

  // code 0 means disconnected: level 0 comes only from its own input
  assign lvl_req[0] = lvl0_req;

  for (genvar lv = 1; lv < LVL_N; lv++) begin : g_lvl
    assign lvl_req[lv] = any_on(dev_code, lv);
  end
endmodule

// File: rtl/pi_ctrl_regs.sv
module pi_ctrl_regs
  import pri_int_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  pi_wr_t wr,
  output logic   sys_on_q,
  output lvl_vec_t lvl_en
);
  logic [LVL_N-1:1] en_q, en_d;
  logic             on_d;
  logic             upd;

  assign upd = wr_en;

  always_comb begin
    if (wr.wipe) begin
      en_d = '0;
      on_d = 1'b0;
    end else begin
      en_d = (en_q | wr.en_set) & ~wr.en_clr;
      on_d = (sys_on_q | wr.sys_on) & ~wr.sys_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      sys_on_q <= 1'b0;
    end else if (upd) begin
      en_q     <= en_d;
      sys_on_q <= on_d;
    end
  end

  // level 0 has no enable of its own
  assign lvl_en = {en_q, 1'b1};
endmodule

// File: rtl/pi_arbiter.sv
module pi_arbiter
  import pri_int_pkg::*;
(
  input  lvl_vec_t lvl_req,
  input  lvl_vec_t lvl_en,
  input  logic     sys_on,
  input  lvl_vec_t held,
  output logic     grant_vld,
  output lvl_num_t grant_lvl
);
  lvl_vec_t blocked;
  lvl_vec_t elig;

  // level n is blocked when any level 0..n is held
  always_comb begin
    blocked[0] = held[0];
    for (int n = 1; n < LVL_N; n++) blocked[n] = blocked[n-1] | held[n];
  end

  assign elig = lvl_req & lvl_en & ~blocked & {LVL_N{sys_on}};

  // scan from least to most urgent so the lowest index wins
  always_comb begin
    grant_vld = 1'b0;
    grant_lvl = '0;
    for (int n = LVL_N-1; n >= 0; n--) begin
      if (elig[n]) begin
        grant_vld = 1'b1;
        grant_lvl = lvl_num_t'(n);
      end
    end
  end
endmodule

// File: rtl/pi_hold_track.sv
module pi_hold_track
  import pri_int_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wipe,
  input  logic     dismiss,
  input  logic     grant_vld,
  input  lvl_num_t grant_lvl,
  output lvl_vec_t held_q
);
  lvl_vec_t held_d;
  lvl_vec_t rel;
  lvl_vec_t set;
  logic     upd;

  // isolate the lowest set bit = most urgent held level
  assign rel = dismiss ? (held_q & (~held_q + lvl_vec_t'(1))) : '0;
  assign set = grant_vld ? (lvl_vec_t'(1) << grant_lvl) : '0;
  assign upd = wipe | dismiss | grant_vld;

  always_comb begin
    if (wipe) held_d = '0;
    else      held_d = (held_q & ~rel) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (upd) held_q <= held_d;
  end
endmodule

// File: rtl/pri_int_ctrl.sv
module pri_int_ctrl
  import pri_int_pkg::*;
#(
  parameter int                NUM_DEV  = 4,
  parameter int                VEC_W    = 6,
  parameter logic [VEC_W-1:0]  VEC_BASE = 6'd32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEV*LVL_W-1:0] dev_code,
  input  logic                     lvl0_req,
  input  logic                     wr_en,
  input  logic [WR_W-1:0]          wr_data,
  input  logic                     dismiss,
  output logic [LVL_N-1:0]         rd_mask,
  output logic                     ack,
  output logic [LVL_W-1:0]         ack_lvl,
  output logic [VEC_W-1:0]         ack_vec
);
  pi_wr_t   wr_s;
  lvl_vec_t lvl_req;
  lvl_vec_t lvl_en;
  lvl_vec_t held_q;
  logic     sys_on_q;
  logic     arb_vld;
  lvl_num_t arb_lvl;
  logic     wipe_now;
  logic     take;

  logic             ack_d;
  lvl_num_t         lvl_d;
  logic [VEC_W-1:0] vec_d;

  assign wr_s     = pi_wr_t'(wr_data);
  assign wipe_now = wr_en & wr_s.wipe;

  pi_req_gather #(.NUM_DEV(NUM_DEV)) u_gather (
    .dev_code (dev_code),
    .lvl0_req (lvl0_req),
    .lvl_req  (lvl_req)
  );

  pi_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr       (wr_s),
    .sys_on_q (sys_on_q),
    .lvl_en   (lvl_en)
  );

  pi_arbiter u_arb (
    .lvl_req   (lvl_req),
    .lvl_en    (lvl_en),
    .sys_on    (sys_on_q),
    .held      (held_q),
    .grant_vld (arb_vld),
    .grant_lvl (arb_lvl)
  );

  // a wipe in the same cycle overrides acceptance
  assign take = arb_vld & ~wipe_now;

  pi_hold_track u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wipe      (wipe_now),
    .dismiss   (dismiss),
    .grant_vld (take),
    .grant_lvl (arb_lvl),
    .held_q    (held_q)
  );

  always_comb begin
    ack_d = take;
    lvl_d = arb_lvl;
    vec_d = VEC_BASE + VEC_W'({arb_lvl, 1'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= ack_d;
  end

  // level and vector only load with a strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_lvl <= '0;
      ack_vec <= '0;
    end else if (ack_d) begin
      ack_lvl <= lvl_d;
      ack_vec <= vec_d;
    end
  end

  assign rd_mask = {lvl_en[LVL_N-1:1], sys_on_q};
endmodule

// File: rtl/pri_int_ctrl_chk.sv
module pri_int_ctrl_chk
  import pri_int_pkg::*;
#(
  parameter int               VEC_W    = 6,
  parameter logic [VEC_W-1:0] VEC_BASE = 6'd32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input lvl_num_t         ack_lvl,
  input logic [VEC_W-1:0] ack_vec,
  input lvl_vec_t         held_q,
  input lvl_vec_t         lvl_en,
  input logic             sys_on,
  input logic             wipe_now
);
  function automatic lvl_vec_t upto(input lvl_num_t l);
    return lvl_vec_t'((16'd2 << l) - 16'd1);
  endfunction

  // R5: acceptance only with the system on before the edge
  a_r5_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(sys_on));

  // R4: the accepted level was enabled
  a_r4_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((($past(lvl_en) >> ack_lvl) & lvl_vec_t'(1)) != '0));

  // R7: no held level at or above the accepted one
  a_r7_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (($past(held_q) & upto(ack_lvl)) == '0));

  // R7: the accepted level is now held
  a_r7_becomes_held: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> held_q[ack_lvl]);

  // R8: at most one hold released per cycle outside a wipe
  a_r8_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wipe_now) |-> ($countones(held_q) + 1 >= $countones($past(held_q))));

  // R10: a wipe leaves nothing held, system off, no strobe
  a_r10_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wipe_now) |-> (held_q == '0 && !sys_on && !ack));

  // R9: vector tracks the level
  a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((ack_vec - VEC_BASE) == VEC_W'({ack_lvl, 1'b0})));
endmodule

bind pri_int_ctrl pri_int_ctrl_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .ack_lvl  (ack_lvl),
  .ack_vec  (ack_vec),
  .held_q   (held_q),
  .lvl_en   (lvl_en),
  .sys_on   (sys_on_q),
  .wipe_now (wipe_now)
);

// File: tb/pri_int_ctrl_tb.sv
module pri_int_ctrl_tb;
  localparam int ND = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [ND*3-1:0] dev_code = '0;
  logic            lvl0_req = 1'b0;
  logic            wr_en = 1'b0;
  logic [16:0]     wr_data = '0;
  logic            dismiss = 1'b0;
  logic [7:0]      rd_mask;
  logic            ack;
  logic [2:0]      ack_lvl;
  logic [5:0]      ack_vec;

  always #4 clk = ~clk;

  pri_int_ctrl #(.NUM_DEV(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_code(dev_code), .lvl0_req(lvl0_req),
    .wr_en(wr_en), .wr_data(wr_data), .dismiss(dismiss),
    .rd_mask(rd_mask), .ack(ack), .ack_lvl(ack_lvl), .ack_vec(ack_vec)
  );

  // behavioural model state
  bit       m_on;
  bit [7:0] m_en;
  bit [7:0] m_held;
  int       n_chk = 0;
  int       n_bad = 0;
  bit       done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: predict from inputs and pre-edge state, then compare
  task automatic cyc(input string tag);
    int       win;
    bit [7:0] lreq;
    bit       wipe;
    bit       blk;
    int       code;
    win  = -1;
    lreq = '0;
    for (int d = 0; d < ND; d++) begin
      code = int'(dev_code[d*3 +: 3]);
      if (code != 0) lreq[code] = 1'b1;
    end
    if (lvl0_req) lreq[0] = 1'b1;
    wipe = wr_en && wr_data[16];
    if (!wipe && m_on) begin
      for (int n = 0; n < 8; n++) begin
        if (win < 0 && lreq[n] && (n == 0 || m_en[n])) begin
          blk = 1'b0;
          for (int j = 0; j <= n; j++) if (m_held[j]) blk = 1'b1;
          if (!blk) win = n;
        end
      end
    end
    if (wipe) begin
      m_on = 0; m_en = '0; m_held = '0;
    end else begin
      if (dismiss) begin
        for (int j = 0; j < 8; j++) begin
          if (m_held[j]) begin
            m_held[j] = 1'b0;
            break;
          end
        end
      end
      if (win >= 0) m_held[win] = 1'b1;
      if (wr_en) begin
        m_en[7:1] = (m_en[7:1] | wr_data[6:0]) & ~wr_data[13:7];
        m_on      = (m_on | wr_data[14]) & ~wr_data[15];
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "ack", int'(ack), (win >= 0) ? 1 : 0);
    if (win >= 0 && ack) begin
      check(tag, "ack_lvl", int'(ack_lvl), win);
      check(tag, "ack_vec", int'(ack_vec), 32 + 2*win);
    end
    check(tag, "rd_mask", int'(rd_mask), int'({m_en[7:1], m_on}));
  endtask

  task automatic wr(input string tag, input bit [6:0] s, input bit [6:0] c,
                    input bit on, input bit off, input bit wipe);
    wr_en   = 1'b1;
    wr_data = {wipe, off, on, c, s};
    cyc(tag);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic dev(input int d, input int code);
    dev_code[d*3 +: 3] = 3'(code);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    m_on = 0; m_en = '0; m_held = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R1");
    cyc("R1");

    // request while off and disabled
    dev(0, 3);
    cyc("R5"); cyc("R5");
    // enable level 3 only, system still off
    wr("R4", 7'b0000100, 7'b0, 0, 0, 0);
    cyc("R5");
    // on/off in one write: off wins
    wr("R5", 7'b0, 7'b0, 1, 1, 0);
    cyc("R5");
    // switch on, enable everything
    wr("R4", 7'h7F, 7'b0, 1, 0, 0);
    cyc("R9");
    dev(0, 0);
    cyc("R7");
    // two levels at once, level 3 already held -> level 2 wins over 5
    dev(1, 5); dev(2, 2);
    cyc("R6"); cyc("R7");
    // level 0 preempts, unmaskable
    lvl0_req = 1'b1;
    cyc("R3"); lvl0_req = 1'b0; cyc("R7");
    // unwind: dismiss releases most urgent first
    dismiss = 1'b1; cyc("R8");
    cyc("R8"); cyc("R8");
    dismiss = 1'b0; cyc("R8"); cyc("R8");
    dismiss = 1'b1; cyc("R8"); cyc("R8"); cyc("R8");
    dismiss = 1'b0;
    dev(1, 0); dev(2, 0);
    cyc("R8");
    // shared level: two devices on 6, disconnected code 0 on the rest
    dev(0, 6); dev(3, 6);
    cyc("R2"); cyc("R2");
    dev(0, 0); dev(3, 0);
    dismiss = 1'b1; cyc("R2"); dismiss = 1'b0;
    cyc("R2"); cyc("R2");
    // clear wins over set for level 4
    wr("R4", 7'b0001000, 7'b0001000, 0, 0, 0);
    dev(1, 4); cyc("R4"); cyc("R4");
    dev(1, 0);
    // write in the same cycle as a request: uses old enables
    dev(2, 7);
    wr("R11", 7'b0, 7'b1000000, 0, 0, 0);
    cyc("R11");
    dev(2, 0);
    // accept and dismiss in the same cycle
    dev(0, 1);
    dismiss = 1'b1; cyc("R11"); dismiss = 1'b0;
    cyc("R11"); cyc("R11");
    dev(0, 0);
    // wipe with a pending request
    dev(3, 2);
    wr("R10", 7'b0, 7'b0, 0, 0, 1);
    cyc("R10");
    wr("R10", 7'h7F, 7'b0, 1, 0, 0);
    cyc("R10"); cyc("R10");
    dev(3, 0);
    wr("R10", 7'b0, 7'b0, 0, 0, 1);
    wr("R10", 7'h7F, 7'b0, 1, 0, 0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      for (int d = 0; d < ND; d++) dev(d, ($urandom % 3 == 0) ? int'($urandom % 8) : 0);
      lvl0_req = ($urandom % 16) == 0;
      dismiss  = ($urandom % 3) == 0;
      if ($urandom % 10 == 0) begin
        wr_en   = 1'b1;
        wr_data = {($urandom % 12) == 0, ($urandom % 6) == 0, ($urandom % 2) == 0,
                   7'($urandom), 7'($urandom)};
      end
      cyc("R6");
      wr_en = 1'b0;
      wr_data = '0;
    end

    done = 1;
    summary();
    $finish;
  end
endmodule